// File: doc/BRIEF.md
# Power Management Capability Register Block

This block holds the two configuration dwords of a power management capability for a PCI-style function. Dword 0 is fixed: an ID byte, a next-pointer byte and a 16-bit capabilities word that reports version 2 and, when a build parameter asks for it, wake support from D0, D3hot and D3cold. Dword 1 carries the control/status word. That word holds a two-bit power-state field, a wake enable bit, a sticky wake status bit and a read-only no-soft-reset flag.

Software reaches the registers through a synchronous configuration port. The port has a dword index, four byte enables and 32-bit write data. Read data is registered and appears one cycle after the read strobe. Writes are decoded by byte lane. When a wake request arrives while the function sits in D3 with wake enabled, the status bit is set and a one-cycle wake-signalled pulse is issued. Each configuration write that changes the decoded power state produces a one-cycle event that carries the old and new state, so that the power controller can act on it.

Top module: `pm_cap_regs`

## Requirements
- R1: After reset the power state is D0 (0), wake enable and wake status are 0, the no-soft-reset bit (bit 3) holds its parameter value, and wake_sent and pwr_evt_valid are low.
- R2: Reading index 0 returns {capabilities word, next pointer, capability ID} in bits [31:16], [15:8] and [7:0]. The capabilities word is 0x0002, with bits 11, 14 and 15 also set when WAKE_SUPPORT is 1. Writes to index 0 change nothing.
- R3: Read data appears on cfg_rdata in the cycle after cfg_rd_en. Index 1 returns the control/status word in bits [15:0] and zero in bits [31:16]. Any index other than 0 or 1 returns zero.
- R4: A write to index 1 with byte enable bit 0 set loads the power state (bits [1:0]) from write data bits [1:0].
- R5: The upper control byte is written only when the byte enables are 4'b0011, 4'b1111 or 4'b0010. It then loads wake enable (bit 8) from write data bit 8. Any other pattern leaves wake enable unchanged.
- R6: Wake status (bit 15) is cleared by an upper-control-byte write with write data bit 15 equal to 1. A 0 in that bit leaves it unchanged.
- R7: A wake_req sampled while the state is 3 (D3) and wake enable is 1 sets wake status and raises wake_sent for exactly one cycle, on the following cycle. In any other state or with wake enable at 0, wake_req has no effect.
- R8: When a wake request that qualifies and a clear of wake status fall in the same cycle, wake status ends up set.
- R9: A write whose decoded state differs from the decoded state before it raises pwr_evt_valid for one cycle, on the following cycle. pwr_evt_from and pwr_evt_to carry the decoded states, encoded as D0 = 2'b00, D3 = 2'b11 and unsupported (raw 1 or 2) = 2'b10. A change between 1 and 2 raises no event.
- R10: Only bits 15, 8, 1 and 0 of the control/status word can be changed by writes. All other bits read as their fixed values, even after writing all ones.
- R11: Writes to any index other than 1 leave the control/status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_idx | input | IDX_W | Dword index inside the capability |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| wake_req | input | 1 | Wake request from the function |
| wake_sent | output | 1 | One-cycle pulse: wake event signalled |
| pwr_evt_valid | output | 1 | One-cycle pulse: power state changed by a write |
| pwr_evt_from | output | 2 | Decoded state before the write |
| pwr_evt_to | output | 2 | Decoded state after the write |

## Verification
The assertions take for granted that reset is applied before any strobe and that the byte enables and index are stable whenever a strobe is high. They make no assumption about wake_req, which may coincide with writes. The stimulus changes inputs only on the falling clock edge and never issues a read and a write in the same cycle. It does place a wake request in the same cycle as a status clear, so that the set-over-clear ordering is exercised on purpose.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;

  typedef enum logic [1:0] {
    PWR_D0    = 2'b00,
    PWR_UNSUP = 2'b10,
    PWR_D3    = 2'b11
  } pwr_e;

  localparam int CTRL_IDX    = 1;
  localparam int BIT_NSR     = 3;
  localparam int BIT_WAKE_EN = 8;
  localparam int BIT_WAKE_ST = 15;

  function automatic pwr_e decode_pwr(input logic [1:0] raw);
    case (raw)
      2'd0:    return PWR_D0;
      2'd3:    return PWR_D3;
      default: return PWR_UNSUP;
    endcase
  endfunction

  function automatic logic [15:0] cap_word(input logic wake_sup);
    logic [15:0] w;
    w = 16'h0002;
    if (wake_sup) w = w | 16'hC800;
    return w;
  endfunction

  function automatic logic [15:0] ctrl_word(input logic [1:0] st, input logic nsr,
                                            input logic en, input logic status);
    logic [15:0] w;
    w = '0;
    w[1:0]         = st;
    w[BIT_NSR]     = nsr;
    w[BIT_WAKE_EN] = en;
    w[BIT_WAKE_ST] = status;
    return w;
  endfunction

  function automatic logic upper_lane_hit(input logic [3:0] be);
    return (be == 4'b0011) || (be == 4'b1111) || (be == 4'b0010);
  endfunction

endpackage

// File: rtl/pm_wr_decode.sv
module pm_wr_decode
  import pm_cap_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic             state_wr,
  output logic [1:0]       state_val,
  output logic             upper_wr,
  output logic             en_val,
  output logic             clr_req
);
  logic hit;
  logic unused_bits;

  assign hit         = wr_en && (idx == IDX_W'(CTRL_IDX));
  assign state_wr    = hit && be[0];
  assign state_val   = wdata[1:0];
  assign upper_wr    = hit && upper_lane_hit(be);
  assign en_val      = wdata[BIT_WAKE_EN];
  assign clr_req     = upper_wr && wdata[BIT_WAKE_ST];
  assign unused_bits = ^{wdata[31:16], wdata[14:9], wdata[7:2]};
endmodule

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs
  import pm_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       state_wr,
  input  logic [1:0] state_val,
  input  logic       upper_wr,
  input  logic       en_val,
  input  logic       clr_req,
  input  logic       wake_req,
  output logic [1:0] state,
  output logic       wake_en,
  output logic       wake_st,
  output logic       wake_sent,
  output logic       evt_valid,
  output logic [1:0] evt_from,
  output logic [1:0] evt_to
);
  logic wake_hit;
  logic state_change;
  pwr_e dec_now;
  pwr_e dec_next;

  assign dec_now      = decode_pwr(state);
  assign dec_next     = decode_pwr(state_val);
  assign wake_hit     = wake_req && (state == 2'd3) && wake_en;
  assign state_change = state_wr && (dec_now != dec_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= 2'd0;
      wake_en   <= 1'b0;
      wake_st   <= 1'b0;
      wake_sent <= 1'b0;
      evt_valid <= 1'b0;
      evt_from  <= 2'b00;
      evt_to    <= 2'b00;
    end else begin
      if (state_wr) state <= state_val;
      if (upper_wr) wake_en <= en_val;
      if (wake_hit) wake_st <= 1'b1;
      else if (clr_req) wake_st <= 1'b0;
      wake_sent <= wake_hit;
      evt_valid <= state_change;
      if (state_change) begin
        evt_from <= dec_now;
        evt_to   <= dec_next;
      end
    end
  end

  p_wake_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_sent |-> $past(wake_req && state == 2'd3 && wake_en));

  p_wake_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_sent |=> !wake_sent || $past(wake_req && state == 2'd3 && wake_en));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && state == 2'd3 && wake_en) |=> wake_st);

  p_state_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !state_wr |=> $stable(state));

  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upper_wr |=> $stable(wake_en));

  p_evt_differs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_from != evt_to));

  p_evt_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(state_wr));
endmodule

// File: rtl/pm_rd_mux.sv
module pm_rd_mux
  import pm_cap_pkg::*;
#(
  parameter int         IDX_W         = 6,
  parameter logic [7:0] CAP_ID        = 8'h01,
  parameter logic [7:0] NEXT_PTR      = 8'h00,
  parameter bit         WAKE_SUPPORT  = 1'b1,
  parameter bit         NO_SOFT_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       state,
  input  logic             wake_en,
  input  logic             wake_st,
  output logic [31:0]      rdata
);
  localparam logic [31:0] DW0 = {cap_word(WAKE_SUPPORT), NEXT_PTR, CAP_ID};

  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (idx == IDX_W'(0)) rd_next = DW0;
    else if (idx == IDX_W'(CTRL_IDX))
      rd_next = {16'h0000, ctrl_word(state, NO_SOFT_RESET, wake_en, wake_st)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  p_dw0_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == IDX_W'(0)) |=> (rdata == DW0));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rdata[31:16] == 16'h0000) || $past(idx == IDX_W'(0)));
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pm_cap_pkg::*;
#(
  parameter int         IDX_W         = 6,
  parameter logic [7:0] CAP_ID        = 8'h01,
  parameter logic [7:0] NEXT_PTR      = 8'h00,
  parameter bit         WAKE_SUPPORT  = 1'b1,
  parameter bit         NO_SOFT_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic             cfg_rd_en,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             wake_req,
  output logic             wake_sent,
  output logic             pwr_evt_valid,
  output logic [1:0]       pwr_evt_from,
  output logic [1:0]       pwr_evt_to
);
  logic       state_wr;
  logic [1:0] state_val;
  logic       upper_wr;
  logic       en_val;
  logic       clr_req;
  logic [1:0] state;
  logic       wake_en;
  logic       wake_st;

  pm_wr_decode #(.IDX_W(IDX_W)) u_dec (
    .wr_en(cfg_wr_en), .idx(cfg_idx), .be(cfg_be), .wdata(cfg_wdata),
    .state_wr(state_wr), .state_val(state_val), .upper_wr(upper_wr),
    .en_val(en_val), .clr_req(clr_req)
  );

  pm_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .state_wr(state_wr), .state_val(state_val),
    .upper_wr(upper_wr), .en_val(en_val), .clr_req(clr_req), .wake_req(wake_req),
    .state(state), .wake_en(wake_en), .wake_st(wake_st), .wake_sent(wake_sent),
    .evt_valid(pwr_evt_valid), .evt_from(pwr_evt_from), .evt_to(pwr_evt_to)
  );

  pm_rd_mux #(
    .IDX_W(IDX_W), .CAP_ID(CAP_ID), .NEXT_PTR(NEXT_PTR),
    .WAKE_SUPPORT(WAKE_SUPPORT), .NO_SOFT_RESET(NO_SOFT_RESET)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(cfg_rd_en), .idx(cfg_idx),
    .state(state), .wake_en(wake_en), .wake_st(wake_st), .rdata(cfg_rdata)
  );

  p_wake_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_sent |-> $past(wake_en));

  p_clear_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !wake_req) |=> !wake_st);
endmodule

// File: tb/tb_pm_cap_regs.sv
module tb_pm_cap_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_rd_en = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        wake_req = 1'b0;
  logic        wake_sent;
  logic        pwr_evt_valid;
  logic [1:0]  pwr_evt_from;
  logic [1:0]  pwr_evt_to;

  int total = 0;
  int bad = 0;
  logic        s_evt, s_wake;
  logic [1:0]  s_from, s_to;
  logic [31:0] s_rd;

  always #10 clk = ~clk;

  pm_cap_regs dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_idx(cfg_idx), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wake_req(wake_req), .wake_sent(wake_sent), .pwr_evt_valid(pwr_evt_valid),
    .pwr_evt_from(pwr_evt_from), .pwr_evt_to(pwr_evt_to)
  );

  // {be[4], wdata[16], ctrl[16], evt, from[2], to[2]}; D0=00 D3=11 unsupported=10
  localparam logic [40:0] VEC [9] = '{
    {4'h1, 16'h0003, 16'h000B, 1'b1, 2'b00, 2'b11},  // R4 R9 D0->D3
    {4'h2, 16'h0100, 16'h010B, 1'b0, 2'b00, 2'b00},  // R5 lane 1 alone
    {4'h3, 16'hFFFF, 16'h010B, 1'b0, 2'b00, 2'b00},  // R10 mask
    {4'h4, 16'h0000, 16'h010B, 1'b0, 2'b00, 2'b00},  // R5 lane 2 only
    {4'h6, 16'h0000, 16'h010B, 1'b0, 2'b00, 2'b00},  // R5 lanes 1-2
    {4'h7, 16'h0000, 16'h0108, 1'b1, 2'b11, 2'b00},  // R4 3 bytes: no upper
    {4'hF, 16'h0001, 16'h0009, 1'b1, 2'b00, 2'b10},  // R9 to unsupported
    {4'h1, 16'h0002, 16'h000A, 1'b0, 2'b00, 2'b00},  // R9 1->2 no event
    {4'hF, 16'h0103, 16'h010B, 1'b1, 2'b10, 2'b11}   // R9 unsupported->D3
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d,
                    input logic req);
    cfg_wr_en = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d; wake_req = req;
    @(negedge clk);
    s_evt = pwr_evt_valid; s_from = pwr_evt_from; s_to = pwr_evt_to; s_wake = wake_sent;
    cfg_wr_en = 1'b0; wake_req = 1'b0;
  endtask

  task automatic rd(input logic [5:0] idx);
    cfg_rd_en = 1'b1; cfg_idx = idx;
    @(negedge clk);
    s_rd = cfg_rdata;
    cfg_rd_en = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1;
    @(negedge clk);
    s_wake = wake_sent;
    wake_req = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 wake_sent", 32'(wake_sent), 0);
    check("R1 evt", 32'(pwr_evt_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(6'd1);
    check("R1 ctrl after reset", s_rd, 32'h0000_0008);

    for (int i = 0; i < 9; i++) begin
      wr(6'd1, VEC[i][40:37], {16'hFFFF, VEC[i][36:21]}, 1'b0);
      check("R9 evt_valid", 32'(s_evt), 32'(VEC[i][4]));
      if (VEC[i][4]) begin
        check("R9 evt_from", 32'(s_from), 32'(VEC[i][3:2]));
        check("R9 evt_to", 32'(s_to), 32'(VEC[i][1:0]));
      end
      rd(6'd1);
      check("R4 R5 R10 ctrl", s_rd, {16'h0, VEC[i][20:5]});
    end

    // state D3, enable 1
    pulse_wake();
    check("R7 wake pulse", 32'(s_wake), 1);
    @(negedge clk);
    check("R7 one cycle", 32'(wake_sent), 0);
    rd(6'd1);
    check("R7 status set", s_rd, 32'h0000_810B);

    wr(6'd1, 4'h2, 32'h0000_0100, 1'b0);
    rd(6'd1);
    check("R6 zero keeps status", s_rd, 32'h0000_810B);
    wr(6'd1, 4'h2, 32'h0000_8100, 1'b0);
    rd(6'd1);
    check("R6 w1c clears", s_rd, 32'h0000_010B);

    wr(6'd1, 4'h2, 32'h0000_8100, 1'b1);
    check("R8 wake pulse", 32'(s_wake), 1);
    rd(6'd1);
    check("R8 set wins", s_rd, 32'h0000_810B);

    wr(6'd1, 4'h2, 32'h0000_8000, 1'b0);
    rd(6'd1);
    check("R7 disabled ctrl", s_rd, 32'h0000_000B);
    pulse_wake();
    check("R7 disabled no pulse", 32'(s_wake), 0);
    rd(6'd1);
    check("R7 disabled no status", s_rd, 32'h0000_000B);

    wr(6'd1, 4'h3, 32'h0000_0100, 1'b0);
    check("R9 D3->D0 evt", 32'(s_evt), 1);
    pulse_wake();
    check("R7 D0 no pulse", 32'(s_wake), 0);
    rd(6'd1);
    check("R7 D0 no status", s_rd, 32'h0000_0108);

    wr(6'd0, 4'hF, 32'hFFFF_FFFF, 1'b0);
    rd(6'd0);
    check("R2 dword0", s_rd, 32'hC802_0001);
    wr(6'd2, 4'hF, 32'hFFFF_FFFF, 1'b0);
    rd(6'd2);
    check("R3 other index zero", s_rd, 32'h0);
    rd(6'd1);
    check("R11 ctrl untouched", s_rd, 32'h0000_0108);

    cfg_rd_en = 1'b1; cfg_idx = 6'd0;
    #1;
    check("R3 not before edge", cfg_rdata, 32'h0000_0108);
    @(negedge clk);
    cfg_rd_en = 1'b0;
    check("R3 after edge", cfg_rdata, 32'hC802_0001);

    wr(6'd1, 4'h1, 32'h0000_0003, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 evt cleared", 32'(pwr_evt_valid), 0);
    rd(6'd1);
    check("R1 ctrl after mid reset", s_rd, 32'h0000_0008);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule